// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block gives a host a narrow way into two wider spaces. The host first writes a 32-bit pointer into the index register. It then reads or writes through a four-byte data window. Bit 31 of the pointer chooses the target of each window access:

- When bit 31 is set, the access goes to a video-memory port. The memory address is the low 31 bits of the pointer plus the byte offset inside the window.
- When bit 31 is clear, the access goes to a word-wide register file. The register address is the pointer plus the same window offset.

Host addresses at and above byte 8 reach the register file directly. The register file in this project is a reset-to-zero stub.

Every access is 1, 2 or 4 bytes wide. Sub-word accesses extract and merge little-endian byte lanes of the 32-bit word that is addressed. Memory accesses are bounds-checked against the memory size, and those that fall outside it are dropped quietly. A memory access takes as many cycles as the memory port needs. While it is in flight the host sees a busy flag, and a one-cycle done pulse marks the end of every access.

Top module: `ixw_window`

## Requirements
- R1: After reset, the index register is 0, and host_busy, host_done and mem_req are all low.
- R2: Host byte addresses 0 to 3 hold the index register. A 4-byte write at 0 stores all 32 bits, and a read returns the stored value. A sub-word write merges only the bytes it addresses. host_done rises in the cycle after the request is accepted.
- R3: Window addresses are host bytes 4 to 7. With index bit 31 set, a window access drives mem_req toward byte address index[30:0] + (host_addr - 4). It forwards the size code (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) and the write data with only its low n bytes kept. A read returns the low n bytes of mem_rdata, zero-extended, where byte 0 is the lowest address.
- R4: A memory access is issued only if its address is at most MEM_BYTES - n. Otherwise no mem_req is raised, a write is lost, and a read returns 0 with host_done in the next cycle.
- R5: mem_req and its fields stay steady until mem_ack. host_busy is high from the cycle after acceptance until completion. host_done comes in the cycle after mem_ack is sampled, which gives a latency of 2 + L cycles for a responder that waits L cycles.
- R6: With index bit 31 clear, a window access reaches the register at byte address index + (host_addr - 4).
- R7: A register read at byte offset k with size n returns bits [8k+8n-1:8k] of the word, shifted down to bit 0. Lanes above byte 3 read as zero.
- R8: A register write at byte offset k with size n changes only bytes k to k+n-1 of the word, and every other byte keeps its value. An aligned 4-byte write replaces the whole word.
- R9: A forwarded access whose target address falls in bytes 0 to 7 (the index or the window) changes nothing and reads 0.
- R10: A register address at or beyond REG_WORDS*4 is ignored and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_req | input | 1 | Access request, accepted when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host byte address |
| host_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| host_wdata | input | 32 | Write data, right-aligned |
| host_busy | output | 1 | A memory access is in flight |
| host_done | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write |
| mem_addr | output | MAW | Memory byte address |
| mem_size | output | 2 | Normalised size code |
| mem_wdata | output | 32 | Write data, low n bytes |
| mem_rdata | input | 32 | Read data, low n bytes |
| mem_ack | input | 1 | Memory completion |

## Verification
The checks assume two things about the inputs. The host never raises host_req while host_busy is high, and the memory side raises mem_ack only for a pending mem_req, for exactly one cycle. The stimulus keeps to both rules: every access is issued by a task that waits for host_done before it returns. The memory responder acknowledges once, after a programmed latency, and then drops mem_ack.

// File: rtl/ixw_pkg.sv
`timescale 1ns/1ps
package ixw_pkg;
   typedef enum logic [1:0] {
      TGT_NONE  = 2'd0,
      TGT_INDEX = 2'd1,
      TGT_REG   = 2'd2,
      TGT_MEM   = 2'd3
   } ixw_tgt_e;

   typedef enum logic {ST_IDLE = 1'b0, ST_MEM = 1'b1} ixw_state_e;

   localparam int unsigned WORD_BYTES  = 4;
   localparam int unsigned WIN_OFS     = 4;
   localparam int unsigned RSVD_BYTES  = 8;

   function automatic logic [2:0] ixw_nbytes(input logic [1:0] sz);
      case (sz)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [31:0] ixw_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/ixw_route.sv
`timescale 1ns/1ps
module ixw_route
   import ixw_pkg::*;
#(
   parameter int unsigned HOST_AW   = 8,
   parameter int unsigned REG_WORDS = 16,
   parameter int unsigned MEM_BYTES = 4096,
   parameter int unsigned RAW       = $clog2(REG_WORDS) + 2,
   parameter int unsigned MAW       = $clog2(MEM_BYTES)
) (
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        index,
   input  logic [1:0]         size,
   output ixw_tgt_e           tgt,
   output logic [RAW-1:0]     reg_addr,
   output logic [MAW-1:0]     mem_addr
);
   logic        is_index;
   logic        in_window;
   logic [1:0]  k;
   logic [31:0] fwd_addr;
   logic [32:0] maddr;
   logic [32:0] mlimit;
   logic        mem_ok;
   logic        reg_ok;

   assign k         = host_addr[1:0];
   assign is_index  = host_addr < HOST_AW'(WIN_OFS);
   assign in_window = !is_index && (host_addr < HOST_AW'(RSVD_BYTES));

   // register-side address: pointer plus window offset, or the host address
   assign fwd_addr = in_window ? (index + 32'(k)) : 32'(host_addr);

   // memory-side address and bound
   assign maddr  = {2'b00, index[30:0]} + 33'(k);
   assign mlimit = 33'(MEM_BYTES) - 33'(ixw_nbytes(size));
   assign mem_ok = maddr <= mlimit;

   assign reg_ok = (fwd_addr >= 32'(RSVD_BYTES)) && (fwd_addr < 32'(REG_WORDS * WORD_BYTES));

   always_comb begin
      if (is_index)                   tgt = TGT_INDEX;
      else if (in_window && index[31]) tgt = mem_ok ? TGT_MEM : TGT_NONE;
      else if (reg_ok)                tgt = TGT_REG;
      else                            tgt = TGT_NONE;
   end

   assign reg_addr = fwd_addr[RAW-1:0];
   assign mem_addr = maddr[MAW-1:0];
endmodule

// File: rtl/ixw_lane.sv
`timescale 1ns/1ps
module ixw_lane
   import ixw_pkg::*;
(
   input  logic [31:0] cur,
   input  logic [1:0]  ofs,
   input  logic [1:0]  size,
   input  logic [31:0] wdata,
   output logic [31:0] rd_val,
   output logic [31:0] wr_word
);
   logic [2:0]  n;
   logic [2:0]  lo;
   logic [31:0] wsh;

   assign n      = ixw_nbytes(size);
   assign lo     = {1'b0, ofs};
   assign wsh    = wdata << {ofs, 3'b000};
   assign rd_val = (cur >> {ofs, 3'b000}) & ixw_mask(size);

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
      logic be;
      assign be = (3'(b) >= lo) && (3'(b) < (lo + n));
      assign wr_word[8*b +: 8] = be ? wsh[8*b +: 8] : cur[8*b +: 8];
   end
endmodule

// File: rtl/ixw_regfile.sv
`timescale 1ns/1ps
module ixw_regfile #(
   parameter int unsigned WORDS = 16,
   parameter int unsigned IW    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [31:0]   wdata,
   input  logic [IW-1:0] ridx,
   output logic [31:0]   rdata
);
   logic [31:0] words [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < int'(WORDS); w++) words[w] <= '0;
      end else if (we) begin
         words[widx] <= wdata;
      end
   end

   assign rdata = words[ridx];

   // words 0 and 1 shadow the index and window; no forwarded write lands there
   assert_no_window_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (widx > IW'(1)));
endmodule

// File: rtl/ixw_window.sv
`timescale 1ns/1ps
module ixw_window
   import ixw_pkg::*;
#(
   parameter int unsigned HOST_AW   = 8,
   parameter int unsigned REG_WORDS = 16,
   parameter int unsigned MEM_BYTES = 4096,
   localparam int unsigned MAW      = $clog2(MEM_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         host_size,
   input  logic [31:0]        host_wdata,
   output logic               host_busy,
   output logic               host_done,
   output logic [31:0]        host_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [MAW-1:0]     mem_addr,
   output logic [1:0]         mem_size,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   input  logic               mem_ack
);
   localparam int unsigned RIW = $clog2(REG_WORDS);
   localparam int unsigned RAW = RIW + 2;

   if (REG_WORDS < 4 || (REG_WORDS & (REG_WORDS - 1)) != 0) begin : g_bad_words
      $error("REG_WORDS must be a power of two, at least 4");
   end
   if (MEM_BYTES < WORD_BYTES) begin : g_bad_mem
      $error("MEM_BYTES must hold at least one word");
   end
   if (HOST_AW < RAW || HOST_AW > 31) begin : g_bad_aw
      $error("HOST_AW must cover the register file and stay below 32");
   end

   ixw_state_e      state_q;
   logic [31:0]     index_q;
   logic            done_q;
   logic [31:0]     rdata_q;
   logic            mreq_q;
   logic            mwe_q;
   logic [MAW-1:0]  maddr_q;
   logic [1:0]      msize_q;
   logic [31:0]     mwdata_q;

   ixw_tgt_e        tgt;
   logic [RAW-1:0]  reg_addr;
   logic [MAW-1:0]  route_maddr;
   logic [31:0]     reg_rdata;
   logic [31:0]     lane_cur;
   logic [1:0]      lane_ofs;
   logic [31:0]     lane_rd;
   logic [31:0]     lane_wr;
   logic            accept;
   logic            reg_we;

   ixw_route #(
      .HOST_AW  (HOST_AW),
      .REG_WORDS(REG_WORDS),
      .MEM_BYTES(MEM_BYTES),
      .RAW      (RAW),
      .MAW      (MAW)
   ) u_route (
      .host_addr(host_addr),
      .index    (index_q),
      .size     (host_size),
      .tgt      (tgt),
      .reg_addr (reg_addr),
      .mem_addr (route_maddr)
   );

   assign lane_cur = (tgt == TGT_INDEX) ? index_q : reg_rdata;
   assign lane_ofs = (tgt == TGT_REG) ? reg_addr[1:0] : host_addr[1:0];

   ixw_lane u_lane (
      .cur    (lane_cur),
      .ofs    (lane_ofs),
      .size   (host_size),
      .wdata  (host_wdata),
      .rd_val (lane_rd),
      .wr_word(lane_wr)
   );

   assign accept = host_req && (state_q == ST_IDLE);
   assign reg_we = accept && host_we && (tgt == TGT_REG);

   ixw_regfile #(.WORDS(REG_WORDS), .IW(RIW)) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we),
      .widx (reg_addr[RAW-1:2]),
      .wdata(lane_wr),
      .ridx (reg_addr[RAW-1:2]),
      .rdata(reg_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         index_q  <= '0;
         done_q   <= 1'b0;
         rdata_q  <= '0;
         mreq_q   <= 1'b0;
         mwe_q    <= 1'b0;
         maddr_q  <= '0;
         msize_q  <= '0;
         mwdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (host_req) begin
                  case (tgt)
                     TGT_INDEX: begin
                        if (host_we) index_q <= lane_wr;
                        rdata_q <= host_we ? 32'd0 : lane_rd;
                        done_q  <= 1'b1;
                     end
                     TGT_REG: begin
                        rdata_q <= host_we ? 32'd0 : lane_rd;
                        done_q  <= 1'b1;
                     end
                     TGT_MEM: begin
                        mreq_q   <= 1'b1;
                        mwe_q    <= host_we;
                        maddr_q  <= route_maddr;
                        msize_q  <= (host_size == 2'd3) ? 2'd2 : host_size;
                        mwdata_q <= host_wdata & ixw_mask(host_size);
                        state_q  <= ST_MEM;
                     end
                     default: begin
                        rdata_q <= '0;
                        done_q  <= 1'b1;
                     end
                  endcase
               end
            end
            ST_MEM: begin
               if (mem_ack) begin
                  mreq_q  <= 1'b0;
                  rdata_q <= mwe_q ? 32'd0 : (mem_rdata & ixw_mask(msize_q));
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign host_busy  = (state_q == ST_MEM);
   assign host_done  = done_q;
   assign host_rdata = rdata_q;
   assign mem_req    = mreq_q;
   assign mem_we     = mwe_q;
   assign mem_addr   = maddr_q;
   assign mem_size   = msize_q;
   assign mem_wdata  = mwdata_q;

   // input contract: no new request while one is in flight
   assert_no_req_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_req && host_busy));
   // input contract: acknowledge only a pending request
   assert_ack_solicited_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ack |-> mem_req);
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_size) && $stable(mem_wdata)));
   assert_busy_covers_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> host_busy);
   assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      host_done |-> !host_busy);
   assert_mem_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((33'(mem_addr) + 33'(ixw_nbytes(mem_size))) <= 33'(MEM_BYTES)));
   assert_mem_from_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(host_req));
endmodule

// File: tb/sim_ixw_window.sv
`timescale 1ns/1ps
module sim_ixw_window;
   localparam int unsigned HOST_AW   = 8;
   localparam int unsigned REG_WORDS = 16;
   localparam int unsigned MEM_BYTES = 4096;
   localparam int unsigned MAW       = $clog2(MEM_BYTES);
   localparam int NV = 38;

   // {tag[79:76], mem[75], we[74], addr[73:66], size[65:64], wdata[63:32], exp[31:0]}
   localparam logic [79:0] VEC [NV] = '{
      {4'd2, 1'b0, 1'b1, 8'h00, 2'd2, 32'h12345678, 32'h0},        // R2 write index
      {4'd2, 1'b0, 1'b0, 8'h00, 2'd2, 32'h0,        32'h12345678}, // R2 read index
      {4'd2, 1'b0, 1'b1, 8'h02, 2'd0, 32'h000000AB, 32'h0},        // R2 byte merge
      {4'd2, 1'b0, 1'b0, 8'h00, 2'd2, 32'h0,        32'h12AB5678}, // R2
      {4'd3, 1'b0, 1'b1, 8'h00, 2'd2, 32'h80000010, 32'h0},        // R3 point at mem 16
      {4'd3, 1'b1, 1'b1, 8'h04, 2'd2, 32'hA1B2C3D4, 32'h0},        // R3 word write
      {4'd3, 1'b1, 1'b0, 8'h04, 2'd2, 32'h0,        32'hA1B2C3D4}, // R3
      {4'd3, 1'b1, 1'b0, 8'h05, 2'd0, 32'h0,        32'h000000C3}, // R3 byte 17
      {4'd3, 1'b1, 1'b0, 8'h06, 2'd1, 32'h0,        32'h0000A1B2}, // R3 bytes 18..19
      {4'd4, 1'b0, 1'b1, 8'h00, 2'd2, 32'h80000FFE, 32'h0},        // R4 point at 4094
      {4'd4, 1'b1, 1'b1, 8'h04, 2'd1, 32'h0000BEEF, 32'h0},        // R4 last legal half
      {4'd4, 1'b1, 1'b0, 8'h04, 2'd1, 32'h0,        32'h0000BEEF}, // R4
      {4'd4, 1'b0, 1'b1, 8'h05, 2'd1, 32'h00001111, 32'h0},        // R4 4095+2 dropped
      {4'd4, 1'b1, 1'b0, 8'h05, 2'd0, 32'h0,        32'h000000BE}, // R4 byte kept
      {4'd4, 1'b0, 1'b0, 8'h04, 2'd2, 32'h0,        32'h0},        // R4 read beyond -> 0
      {4'd6, 1'b0, 1'b1, 8'h00, 2'd2, 32'h00000020, 32'h0},        // R6 point at reg 0x20
      {4'd6, 1'b0, 1'b1, 8'h04, 2'd2, 32'hCAFEF00D, 32'h0},        // R6 forwarded write
      {4'd6, 1'b0, 1'b0, 8'h20, 2'd2, 32'h0,        32'hCAFEF00D}, // R6 direct readback
      {4'd8, 1'b0, 1'b1, 8'h05, 2'd0, 32'h00000077, 32'h0},        // R8 byte 1
      {4'd8, 1'b0, 1'b0, 8'h20, 2'd2, 32'h0,        32'hCAFE770D}, // R8
      {4'd7, 1'b0, 1'b0, 8'h06, 2'd1, 32'h0,        32'h0000CAFE}, // R7 upper half
      {4'd7, 1'b0, 1'b0, 8'h23, 2'd1, 32'h0,        32'h000000CA}, // R7 lanes past 3 zero
      {4'd8, 1'b0, 1'b1, 8'h22, 2'd2, 32'h11223344, 32'h0},        // R8 offset 2 word
      {4'd8, 1'b0, 1'b0, 8'h20, 2'd2, 32'h0,        32'h3344770D}, // R8
      {4'd9, 1'b0, 1'b1, 8'h00, 2'd2, 32'h00000004, 32'h0},        // R9 point at window
      {4'd9, 1'b0, 1'b1, 8'h04, 2'd2, 32'h0000DEAD, 32'h0},        // R9 ignored
      {4'd9, 1'b0, 1'b0, 8'h00, 2'd2, 32'h0,        32'h00000004}, // R9 index kept
      {4'd9, 1'b0, 1'b0, 8'h04, 2'd2, 32'h0,        32'h0},        // R9 reads 0
      {4'd9, 1'b0, 1'b1, 8'h00, 2'd2, 32'h0,        32'h0},        // R9 point at index
      {4'd9, 1'b0, 1'b1, 8'h04, 2'd2, 32'h00005555, 32'h0},        // R9 ignored
      {4'd9, 1'b0, 1'b0, 8'h00, 2'd2, 32'h0,        32'h0},        // R9 index kept
      {4'd10, 1'b0, 1'b1, 8'h40, 2'd2, 32'h00000099, 32'h0},       // R10 past end
      {4'd10, 1'b0, 1'b0, 8'h40, 2'd2, 32'h0,        32'h0},       // R10 reads 0
      {4'd6, 1'b0, 1'b1, 8'h00, 2'd2, 32'h0000003C, 32'h0},        // R6 point at last word
      {4'd6, 1'b0, 1'b1, 8'h07, 2'd0, 32'h000000EE, 32'h0},        // R6 byte 0x3F
      {4'd6, 1'b0, 1'b0, 8'h3C, 2'd2, 32'h0,        32'hEE000000}, // R6
      {4'd10, 1'b0, 1'b1, 8'h00, 2'd2, 32'h00000040, 32'h0},       // R10 forward past end
      {4'd10, 1'b0, 1'b0, 8'h04, 2'd2, 32'h0,        32'h0}        // R10 reads 0
   };

   logic               clk = 1'b0;
   logic               rst_n;
   logic               host_req;
   logic               host_we;
   logic [HOST_AW-1:0] host_addr;
   logic [1:0]         host_size;
   logic [31:0]        host_wdata;
   logic               host_busy;
   logic               host_done;
   logic [31:0]        host_rdata;
   logic               mem_req;
   logic               mem_we;
   logic [MAW-1:0]     mem_addr;
   logic [1:0]         mem_size;
   logic [31:0]        mem_wdata;
   logic [31:0]        mem_rdata;
   logic               mem_ack;

   int tests = 0;
   int fails = 0;
   int cur_lat = 0;
   int lat_cnt = 0;
   int mreq_rises = 0;
   logic mreq_prev = 1'b0;
   bit finished = 1'b0;
   logic [7:0] mem_model [MEM_BYTES];

   always #2 clk = ~clk;

   ixw_window #(
      .HOST_AW(HOST_AW), .REG_WORDS(REG_WORDS), .MEM_BYTES(MEM_BYTES)
   ) u0 (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata),
      .host_busy(host_busy), .host_done(host_done), .host_rdata(host_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   function automatic int nb(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
   endfunction

   // memory responder, acting away from the active edge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
         lat_cnt <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
      end else if (mem_req) begin
         if (lat_cnt >= cur_lat) begin
            logic [31:0] rtmp;
            rtmp = '0;
            for (int i = 0; i < nb(mem_size); i++) begin
               if (mem_we) mem_model[int'(mem_addr) + i] = mem_wdata[8*i +: 8];
               else        rtmp[8*i +: 8] = mem_model[int'(mem_addr) + i];
            end
            mem_rdata <= rtmp;
            mem_ack   <= 1'b1;
            lat_cnt   <= 0;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   always @(posedge clk) begin
      if (mem_req && !mreq_prev) mreq_rises <= mreq_rises + 1;
      mreq_prev <= mem_req;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic we, input logic [7:0] addr, input logic [1:0] size,
                         input logic [31:0] wdata, output logic [31:0] rd,
                         output int cyc, output bit saw_busy);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = addr;
      host_size = size; host_wdata = wdata;
      @(negedge clk);
      host_req = 1'b0;
      cyc = 1;
      saw_busy = host_busy;
      while (!host_done && cyc < 64) begin
         @(negedge clk);
         cyc++;
         if (host_busy) saw_busy = 1'b1;
      end
      rd = host_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int cyc;
      bit busy_seen;
      int exp_mem;
      for (int a = 0; a < int'(MEM_BYTES); a++) mem_model[a] = 8'h00;
      rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
      host_size = '0; host_wdata = '0; mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", 32'(host_busy), 32'd0);
      check("R1 done", 32'(host_done), 32'd0);
      check("R1 mem_req", 32'(mem_req), 32'd0);
      run_op(1'b0, 8'h00, 2'd2, 32'h0, rd, cyc, busy_seen);
      check("R1 index", rd, 32'h0);

      exp_mem = 0;
      for (int i = 0; i < NV; i++) begin
         logic [79:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[79:76], i);
         cur_lat = i % 4;
         if (v[75]) exp_mem++;
         run_op(v[74], v[73:66], v[65:64], v[63:32], rd, cyc, busy_seen);
         if (!v[74]) check(tag, rd, v[31:0]);
         // R5 latency: register 1 cycle, memory 2 + responder wait
         check({tag, " latency R5"}, 32'(cyc), v[75] ? 32'(2 + cur_lat) : 32'd1);
         check({tag, " busy R5"}, 32'(busy_seen), 32'(v[75]));
      end
      // R4: out-of-bounds accesses never raised mem_req
      check("R4 mem request count", 32'(mreq_rises), 32'(exp_mem));
      // R3: size code 3 behaves as 4 bytes
      run_op(1'b1, 8'h00, 2'd2, 32'h80000100, rd, cyc, busy_seen);
      cur_lat = 2;
      run_op(1'b1, 8'h04, 2'd3, 32'h0BADF00D, rd, cyc, busy_seen);
      run_op(1'b0, 8'h04, 2'd2, 32'h0, rd, cyc, busy_seen);
      check("R3 size code 3", rd, 32'h0BADF00D);
      check("R3 byte order", 32'(mem_model[256]), 32'h0D);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule